// File: doc/BRIEF.md
# Framebuffer Control and Status Registers with Frame Interrupt

This block is the byte-wide register window of a simple framebuffer. It covers the byte offsets 0x10 to 0x1F of the device's register space. A host writes a control byte whose bit 7 arms a per-frame interrupt. The display pipeline pulses `frame_end` once per frame. While the interrupt is armed, each pulse latches a pending flag, and that flag drives the level output `irq`.

The host reads the pending flag in bit 7 of the status byte at offset 0x11. The other bits of that byte are wired constants: a monitor sense code (0x60) and a colour board marker (0x01). Any write to the status byte acknowledges the interrupt. The remaining offsets hold plain storage bytes used for cursor start, cursor end and video control settings. Reads are combinational from `acc_addr` while `acc_en` is high. Writes take effect at the clock edge when `acc_en` and `acc_wr` are both high.

Top module: `fb_ctl_regs`

## Requirements
- R1: After reset `irq` is low, offset 0x10 and offsets 0x12 to 0x1F read 0x00, and offset 0x11 reads 0x61.
- R2: A write to offset 0x10 stores the whole byte, and reads of 0x10 return it unchanged. Bit 7 of this byte is the interrupt enable.
- R3: A read of offset 0x11 returns the pending flag in bit 7 and the constant 0x61 in bits 6:0. Writes never change bits 6:0.
- R4: A `frame_end` pulse in a cycle where the stored control bit 7 is 1 sets the pending flag, and `irq` is high from the next cycle on. With control bit 7 at 0, the pulse has no effect.
- R5: A write of any data value to offset 0x11 clears the pending flag, and `irq` is low from the next cycle on.
- R6: When a `frame_end` pulse with the enable set coincides with a write to offset 0x11, the flag ends up set.
- R7: `irq` equals the pending flag. It holds its value while neither a frame pulse nor a status write occurs, and clearing control bit 7 does not clear it.
- R8: Offsets 0x12 to 0x1F are independent read/write bytes.
- R9: Offsets 0x00 to 0x0F read as 0x00, and writes to them change no register and do not change `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, 0 when idle or off-window |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Level interrupt, equals pending flag |

## Verification
The hardest case to reach from the ports is a frame pulse that lands in the same clock edge as an acknowledge write to the status byte, with the enable armed. The stimulus forces this collision directly. It also forces the unarmed variant, and the random phase strikes both cases again because it draws frame pulses and status writes independently every cycle. A second subtle case is disarming the enable while a flag is pending. The bench checks this case too, because the flag must survive until it is acknowledged.

// File: rtl/fb_ctl_regs.sv
module fb_ctl_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int BASE = 16,
  parameter int SPAN = 16,
  parameter int IRQ_BIT = 7,
  parameter logic [DATA_W-1:0] ID_BITS = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              frame_end,
  output logic              irq
);
  localparam int OFS_W = $clog2(SPAN);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SPAN);
  localparam logic [OFS_W-1:0] CTRL_IX = OFS_W'(0);
  localparam logic [OFS_W-1:0] STAT_IX = OFS_W'(1);

  logic [DATA_W-1:0] bank [SPAN];
  logic              pend_q;
  logic [ADDR_W:0]   addr_x;
  logic              in_win;
  logic [OFS_W-1:0]  ofs;
  logic              wr_hit;
  logic              stat_wr;
  logic              arm;
  logic [ADDR_W-1:0] rel;

  assign addr_x  = {1'b0, acc_addr};
  assign in_win  = (addr_x >= LO) && (addr_x < HI);
  assign rel     = acc_addr - ADDR_W'(BASE);
  assign ofs     = rel[OFS_W-1:0];
  assign wr_hit  = acc_en && acc_wr && in_win;
  assign stat_wr = wr_hit && (ofs == STAT_IX);
  assign arm     = bank[CTRL_IX][IRQ_BIT];
  assign irq     = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPAN; i++) bank[i] <= '0;
    end else if (wr_hit && ofs != STAT_IX) begin
      bank[ofs] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (frame_end && arm)  pend_q <= 1'b1;
    else if (stat_wr)           pend_q <= 1'b0;
  end

  always_comb begin
    if (!acc_en || !in_win)     acc_rdata = '0;
    else if (ofs == STAT_IX)    acc_rdata = ID_BITS | (DATA_W'(pend_q) << IRQ_BIT);
    else                        acc_rdata = bank[ofs];
  end

  a_r4_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && arm) |=> irq);
  a_r4_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !arm && !irq) |=> !irq);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !frame_end) |=> !irq);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && frame_end && arm) |=> irq);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !stat_wr) |=> $stable(irq));
  a_r3_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && in_win && ofs == STAT_IX) |-> (acc_rdata[IRQ_BIT] == irq));
  a_r9_off_window: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !in_win) |-> (acc_rdata == '0));
endmodule

// File: tb/test_fb_ctl_regs.sv
`timescale 1ns/1ps
module test_fb_ctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0, frame_end = 1'b0;
  logic [4:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_bank [16];
  logic m_pend;

  always #2 clk = ~clk;

  fb_ctl_regs i_fb_ctl_regs (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .frame_end(frame_end), .irq(irq));

  function automatic logic [7:0] exp_read(logic [4:0] a);
    if (a < 5'h10) return 8'h00;
    if (a == 5'h11) return {m_pend, 7'h61};
    return m_bank[a - 5'h10];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, logic [4:0] a);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; frame_end = 1'b0;
    #0.5;
    check(req, acc_rdata, exp_read(a));
    acc_en = 1'b0;
  endtask

  // one clock: drive at negedge, update model, check irq at next negedge
  task automatic step(logic we, logic [4:0] a, logic [7:0] d, logic fe, string req);
    logic arm;
    @(negedge clk);
    acc_en = we; acc_wr = we; acc_addr = a; acc_wdata = d; frame_end = fe;
    @(posedge clk);
    arm = m_bank[0][7];
    if (we && a >= 5'h10 && a != 5'h11) m_bank[a - 5'h10] = d;
    if (fe && arm) m_pend = 1'b1;
    else if (we && a == 5'h11) m_pend = 1'b0;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; frame_end = 1'b0;
    check(req, {7'd0, irq}, {7'd0, m_pend});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_bank[i] = 8'h00;
    m_pend = 1'b0;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    read_chk("R1 ctrl", 5'h10);
    read_chk("R1 status", 5'h11);
    for (int a = 18; a < 32; a++) read_chk("R1 store", 5'(a));
    // R2 control readback
    step(1, 5'h10, 8'h5a, 0, "R2 irq");
    read_chk("R2 ctrl", 5'h10);
    // R4 unarmed frame does nothing
    step(0, 5'h00, 8'h00, 1, "R4 unarmed");
    // arm, then frame sets
    step(1, 5'h10, 8'h80, 0, "R2 arm");
    step(0, 5'h00, 8'h00, 1, "R4 set");
    read_chk("R3 status pend", 5'h11);
    // R7 disarm keeps pending
    step(1, 5'h10, 8'h00, 0, "R7 disarm keeps");
    step(0, 5'h00, 8'h00, 0, "R7 hold");
    // R5 ack with arbitrary data, R3 bits untouched
    step(1, 5'h11, 8'h00, 0, "R5 ack zero");
    read_chk("R3 status after ack", 5'h11);
    step(1, 5'h10, 8'h80, 0, "R2 rearm");
    step(0, 5'h00, 8'h00, 1, "R4 set2");
    step(1, 5'h11, 8'hff, 0, "R5 ack ff");
    // R6 coincidence, armed then with flag already set
    step(1, 5'h11, 8'h3c, 1, "R6 collide clear");
    step(1, 5'h11, 8'h3c, 1, "R6 collide set");
    // unarmed collision clears
    step(1, 5'h10, 8'h7f, 0, "R2 disarm");
    step(1, 5'h11, 8'h01, 1, "R6 unarmed collide");
    // R8 storage
    for (int a = 18; a < 32; a++) step(1, 5'(a), 8'(a * 7 + 3), 0, "R8 write");
    for (int a = 18; a < 32; a++) read_chk("R8 store", 5'(a));
    // R9 off-window writes ignored
    step(1, 5'h10, 8'h80, 0, "R2 arm3");
    step(0, 5'h00, 8'h00, 1, "R4 set3");
    for (int a = 0; a < 16; a++) step(1, 5'(a), 8'hff, 0, "R9 ignored irq");
    for (int a = 0; a < 32; a++) read_chk("R9 window", 5'(a));
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a;
      logic we, fe;
      a  = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) a = 5'h11;
      else if ($urandom_range(0, 5) == 0) a = 5'h10;
      we = 1'($urandom_range(0, 1));
      fe = ($urandom_range(0, 3) == 0);
      step(we, a, 8'($urandom), fe, "R7 random irq");
      read_chk("R8 random read", 5'($urandom_range(0, 31)));
    end
    finish_run();
  end
endmodule